// File: doc/BRIEF.md
# Chained DMA Channel Controller

This block is one memory-to-memory DMA channel. Software loads a source address, a destination address, an element count, an optional second count and a control word through a write-only register port. Setting the go bit in the control word starts the channel. The channel then moves one element at a time: it reads the element at the source address, holds it in an internal staging word, and writes it to the destination address. No processor load or store instructions take part.

Each element takes one read request and one write request on a plain request/acknowledge memory interface. Elements are either 16 or 32 bits wide. After every element, each address moves up or down by the element size, and the count goes down by one.

When chaining is enabled and the first count runs out, the second count is loaded into the count register and the transfer carries on without a break. The source and destination registers carry on from where they stopped, so the source register serves as the address of the chained block. The chain enable clears after one reload. Busy, a one-cycle done pulse, a chained flag and the live address and count registers go to the execution unit that collects channel status.

Top module: `dma_chain_channel`

## Requirements
- R1: During and right after reset, `busy`, `done`, `chained` and `mem_req` are 0, and `stat_src`, `stat_dst` and `stat_cnt` are 0.
- R2: A register write while the channel is idle updates the addressed register, and the new value appears on the status outputs after the next clock edge. The register index selects the register: 1 is the source address, 2 the destination address, 3 the element count, 4 the chained count and 0 the control word. The control word bits are: bit 0 go, bit 1 source decrement, bit 2 destination decrement, bit 3 wide element (1 = 32-bit, 0 = 16-bit), bit 4 chain enable.
- R3: A control write with go set and a non-zero count makes `busy` and `mem_req` high in the next cycle. That first request is a read (`mem_we` = 0) at the programmed source address.
- R4: For every element, a read at the current source address is followed by a write (`mem_we` = 1) at the current destination address. The write data is the data that the read returned.
- R5: After each acknowledged write, each address changes by the element size: 4 for wide elements, 2 for narrow ones. It is added when the address's decrement bit is clear and subtracted when the bit is set.
- R6: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` keep their values into the next cycle.
- R7: The count drops by one per acknowledged write. When it reaches zero without a chain reload, `done` is high for exactly one cycle, `busy` goes low in that same cycle, and no further request is made.
- R8: When the count reaches zero with chain enable set and a non-zero chained count, the chained count is loaded, chain enable clears and `chained` goes high. The next read follows without a gap, at the continued source address. `done` is raised only after the chained block ends. If the chained count is zero, the channel finishes as in R7 and `chained` stays 0.
- R9: A go with a count of zero raises `done` in the next cycle and issues no memory request, whether or not chain enable is set.
- R10: Register writes made while `busy` is high, including a go, are ignored. The transfer continues with the addresses and count it started with.
- R11: `mem_size` shows the element width of the running transfer (1 = 32-bit, 0 = 16-bit). In 16-bit mode, only the low 16 bits of the read data are kept, and the upper 16 bits of `mem_wdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_idx | input | 3 | Register index |
| reg_wr_data | input | 32 | Register write data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write request, 0 = read request |
| mem_size | output | 1 | Element width, 1 = 32-bit, 0 = 16-bit |
| mem_addr | output | ADDR_W | Request address |
| mem_wdata | output | DATA_W | Write data |
| mem_ack | input | 1 | Request accepted this cycle |
| mem_rdata | input | DATA_W | Read data, valid with `mem_ack` on a read |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| chained | output | 1 | A chain reload happened in this transfer |
| stat_src | output | ADDR_W | Live source address |
| stat_dst | output | ADDR_W | Live destination address |
| stat_cnt | output | CNT_W | Live element count |

## Verification
Two things can happen on the same clock edge: the acknowledge of the last write in the first block, and the chain reload. On that edge both addresses step, the chained count replaces the expiring count, and the sequencer turns straight back to reading. The bench provokes this with chain enable set and memory latencies of 0 and 1. It then checks that the read and write address logs run on without a jump across the boundary, that exactly one done pulse appears, and that it comes only at the end of the chained block. A second run with a zero chained count confirms that the same edge then ends the transfer instead.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

   // Register indices on the write port
   localparam logic [2:0] IDX_CTRL  = 3'd0;
   localparam logic [2:0] IDX_SRC   = 3'd1;
   localparam logic [2:0] IDX_DST   = 3'd2;
   localparam logic [2:0] IDX_CNT   = 3'd3;
   localparam logic [2:0] IDX_CHCNT = 3'd4;

   // Control word bit positions
   localparam int CB_GO      = 0;
   localparam int CB_SRC_DEC = 1;
   localparam int CB_DST_DEC = 2;
   localparam int CB_WIDE    = 3;
   localparam int CB_CHAIN   = 4;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ  = 2'd1,
      ST_WRITE = 2'd2
   } xfer_state_e;

   typedef struct packed {
      logic chain_en;
      logic wide;
      logic dst_dec;
      logic src_dec;
   } chan_ctrl_t;

endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
   parameter int ADDR_W    = 32,
   parameter bit NARROW_OK = 1'b1
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              dec_i,
   input  logic              wide_i,
   output logic [ADDR_W-1:0] addr_o
);
   localparam logic [ADDR_W-1:0] STEP_WIDE   = ADDR_W'(4);
   localparam logic [ADDR_W-1:0] STEP_NARROW = ADDR_W'(2);

   logic [ADDR_W-1:0] step;

   generate
      if (NARROW_OK) begin : g_two_sizes
         assign step = wide_i ? STEP_WIDE : STEP_NARROW;
      end else begin : g_wide_only
         logic unused_wide;
         assign unused_wide = wide_i;
         assign step = STEP_WIDE;
      end
   endgenerate

   assign addr_o = dec_i ? (addr_i - step) : (addr_i + step);

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
   import dma_chain_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int CNT_W     = 16,
   parameter bit NARROW_OK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_idx,
   input  logic [31:0]       wr_data,
   input  logic              lock,
   input  logic              step,
   input  logic              reload,
   output logic              go,
   output chan_ctrl_t        ctrl,
   output logic              wide_eff,
   output logic [ADDR_W-1:0] src,
   output logic [ADDR_W-1:0] dst,
   output logic [CNT_W-1:0]  cnt,
   output logic              cnt_zero,
   output logic              cnt_last,
   output logic              chcnt_nz
);
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic [CNT_W-1:0]  chcnt;
   logic [ADDR_W-1:0] src_nx;
   logic [ADDR_W-1:0] dst_nx;
   logic              wr_ok;

   assign wr_ok = wr_en && !lock;
   assign go    = wr_ok && (wr_idx == IDX_CTRL) && wr_data[CB_GO];

   generate
      if (NARROW_OK) begin : g_width_sel
         assign wide_eff = ctrl.wide;
      end else begin : g_width_fixed
         assign wide_eff = 1'b1;
      end
   endgenerate

   dma_addr_step #(.ADDR_W(ADDR_W), .NARROW_OK(NARROW_OK)) u_src_step (
      .addr_i (src),
      .dec_i  (ctrl.src_dec),
      .wide_i (wide_eff),
      .addr_o (src_nx)
   );

   dma_addr_step #(.ADDR_W(ADDR_W), .NARROW_OK(NARROW_OK)) u_dst_step (
      .addr_i (dst),
      .dec_i  (ctrl.dst_dec),
      .wide_i (wide_eff),
      .addr_o (dst_nx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl  <= '0;
         src   <= '0;
         dst   <= '0;
         cnt   <= '0;
         chcnt <= '0;
      end else begin
         if (wr_ok) begin
            case (wr_idx)
               IDX_CTRL: begin
                  ctrl.src_dec  <= wr_data[CB_SRC_DEC];
                  ctrl.dst_dec  <= wr_data[CB_DST_DEC];
                  ctrl.wide     <= wr_data[CB_WIDE];
                  ctrl.chain_en <= wr_data[CB_CHAIN];
               end
               IDX_SRC:   src   <= wr_data[ADDR_W-1:0];
               IDX_DST:   dst   <= wr_data[ADDR_W-1:0];
               IDX_CNT:   cnt   <= wr_data[CNT_W-1:0];
               IDX_CHCNT: chcnt <= wr_data[CNT_W-1:0];
               default: ;
            endcase
         end
         if (step) begin
            src <= src_nx;
            dst <= dst_nx;
            if (reload) begin
               cnt           <= chcnt;
               ctrl.chain_en <= 1'b0;
            end else begin
               cnt <= cnt - CNT_ONE;
            end
         end
      end
   end

   assign cnt_zero = (cnt == '0);
   assign cnt_last = (cnt == CNT_ONE);
   assign chcnt_nz = (chcnt != '0);

   AST_RELOAD_TAKES_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
      reload |=> (cnt == $past(chcnt)) && !ctrl.chain_en); // R8

endmodule

// File: rtl/dma_data_buf.sv
module dma_data_buf #(
   parameter int DATA_W    = 32,
   parameter bit NARROW_OK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic              wide,
   input  logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] wdata
);
   localparam int HALF_W = DATA_W / 2;

   logic [DATA_W-1:0] fill;

   generate
      if (NARROW_OK) begin : g_mask
         assign fill = wide ? rdata : {{(DATA_W-HALF_W){1'b0}}, rdata[HALF_W-1:0]};
      end else begin : g_pass
         logic unused_wide;
         assign unused_wide = wide;
         assign fill = rdata;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         wdata <= '0;
      else if (capture)
         wdata <= fill;
   end

endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
   import dma_chain_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   input  logic cnt_zero,
   input  logic cnt_last,
   input  logic chain_en,
   input  logic chcnt_nz,
   input  logic mem_ack,
   output logic rd_req,
   output logic wr_req,
   output logic capture,
   output logic step,
   output logic reload,
   output logic busy,
   output logic done,
   output logic chained
);
   xfer_state_e state_q, state_d;
   logic        finish;

   assign rd_req  = (state_q == ST_READ);
   assign wr_req  = (state_q == ST_WRITE);
   assign capture = rd_req && mem_ack;
   assign step    = wr_req && mem_ack;
   assign reload  = step && cnt_last && chain_en && chcnt_nz;
   assign finish  = step && cnt_last && !reload;
   assign busy    = (state_q != ST_IDLE);

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:  if (go && !cnt_zero) state_d = ST_READ;
         ST_READ:  if (mem_ack) state_d = ST_WRITE;
         ST_WRITE: if (mem_ack) state_d = finish ? ST_IDLE : ST_READ;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         done    <= 1'b0;
         chained <= 1'b0;
      end else begin
         state_q <= state_d;
         done    <= (go && cnt_zero) || finish;
         if (go)
            chained <= 1'b0;
         else if (reload)
            chained <= 1'b1;
      end
   end

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R7
   AST_CHAIN_KEEPS_GOING: assert property (@(posedge clk) disable iff (!rst_n)
      reload |=> chained && busy && rd_req); // R8
   AST_ZERO_GO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (go && cnt_zero && !busy) |=> done && !busy); // R9

endmodule

// File: rtl/dma_chain_channel.sv
module dma_chain_channel
   import dma_chain_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int CNT_W     = 16,
   parameter bit NARROW_OK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [2:0]        reg_wr_idx,
   input  logic [31:0]       reg_wr_data,
   output logic              mem_req,
   output logic              mem_we,
   output logic              mem_size,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              busy,
   output logic              done,
   output logic              chained,
   output logic [ADDR_W-1:0] stat_src,
   output logic [ADDR_W-1:0] stat_dst,
   output logic [CNT_W-1:0]  stat_cnt
);
   localparam logic [ADDR_W-1:0] STEP4 = ADDR_W'(4);
   localparam logic [ADDR_W-1:0] STEP2 = ADDR_W'(2);

   generate
      if (ADDR_W < 16 || ADDR_W > 32) begin : g_bad_addr_w
         $error("ADDR_W must lie in 16..32");
      end
      if (DATA_W != 32) begin : g_bad_data_w
         $error("DATA_W must be 32 to carry both element widths");
      end
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt_w
         $error("CNT_W must lie in 2..32");
      end
   endgenerate

   chan_ctrl_t        ctrl;
   logic              go, wide_eff;
   logic              cnt_zero, cnt_last, chcnt_nz;
   logic              rd_req, wr_req, capture, step, reload;

   dma_chan_regs #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W), .NARROW_OK(NARROW_OK)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_wr_en),
      .wr_idx   (reg_wr_idx),
      .wr_data  (reg_wr_data),
      .lock     (busy),
      .step     (step),
      .reload   (reload),
      .go       (go),
      .ctrl     (ctrl),
      .wide_eff (wide_eff),
      .src      (stat_src),
      .dst      (stat_dst),
      .cnt      (stat_cnt),
      .cnt_zero (cnt_zero),
      .cnt_last (cnt_last),
      .chcnt_nz (chcnt_nz)
   );

   dma_xfer_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (go),
      .cnt_zero (cnt_zero),
      .cnt_last (cnt_last),
      .chain_en (ctrl.chain_en),
      .chcnt_nz (chcnt_nz),
      .mem_ack  (mem_ack),
      .rd_req   (rd_req),
      .wr_req   (wr_req),
      .capture  (capture),
      .step     (step),
      .reload   (reload),
      .busy     (busy),
      .done     (done),
      .chained  (chained)
   );

   dma_data_buf #(.DATA_W(DATA_W), .NARROW_OK(NARROW_OK)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (capture),
      .wide    (wide_eff),
      .rdata   (mem_rdata),
      .wdata   (mem_wdata)
   );

   assign mem_req  = rd_req || wr_req;
   assign mem_we   = wr_req;
   assign mem_size = wide_eff;
   assign mem_addr = wr_req ? stat_dst : stat_src;

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> mem_req && (mem_addr == $past(mem_addr))
         && (mem_we == $past(mem_we)) && (mem_wdata == $past(mem_wdata))); // R6
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy && !mem_req); // R7
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req); // R9
   AST_DST_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !(mem_req && mem_we && mem_ack)) |=> (stat_dst == $past(stat_dst))); // R10
   AST_DST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && mem_ack) |=>
         ((stat_dst - $past(stat_dst)) == ($past(mem_size) ? STEP4 : STEP2))
      || (($past(stat_dst) - stat_dst) == ($past(mem_size) ? STEP4 : STEP2))); // R5

endmodule

// File: tb/tb_dma_chain_channel.sv
`timescale 1ns/1ps
module tb_dma_chain_channel;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [2:0]  reg_wr_idx = '0;
   logic [31:0] reg_wr_data = '0;
   logic        mem_req, mem_we, mem_size;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        busy, done, chained;
   logic [31:0] stat_src, stat_dst;
   logic [15:0] stat_cnt;

   always #2.5 clk = ~clk;

   dma_chain_channel dut (
      .clk(clk), .rst_n(rst_n),
      .reg_wr_en(reg_wr_en), .reg_wr_idx(reg_wr_idx), .reg_wr_data(reg_wr_data),
      .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .busy(busy), .done(done), .chained(chained),
      .stat_src(stat_src), .stat_dst(stat_dst), .stat_cnt(stat_cnt)
   );

   int n_checks = 0;
   int n_err = 0;
   int lat = 0;
   int wait_cnt = 0;
   int n_rd = 0, n_wr = 0, done_cnt = 0, req_cycles = 0;
   logic [31:0] rd_log [64];
   logic [31:0] wa_log [64];
   logic [31:0] wd_log [64];
   logic        ws_log [64];

   function automatic logic [31:0] pat(input logic [31:0] a);
      return {~a[15:0], a[15:0]} ^ 32'h1234_8001;
   endfunction

   // memory model and monitors, all on the falling edge
   always @(negedge clk) begin
      if (!rst_n) begin
         mem_ack = 1'b0;
         wait_cnt = 0;
      end else if (mem_ack) begin
         mem_ack = 1'b0;
      end else if (mem_req) begin
         if (wait_cnt >= lat) begin
            mem_ack = 1'b1;
            wait_cnt = 0;
            if (mem_we) begin
               if (n_wr < 64) begin
                  wa_log[n_wr] = mem_addr;
                  wd_log[n_wr] = mem_wdata;
                  ws_log[n_wr] = mem_size;
               end
               n_wr++;
            end else begin
               if (n_rd < 64) rd_log[n_rd] = mem_addr;
               n_rd++;
               mem_rdata = pat(mem_addr);
            end
         end else begin
            wait_cnt++;
         end
      end
      if (rst_n && done) done_cnt++;
      if (rst_n && mem_req) req_cycles++;
   end

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic reg_write(input logic [2:0] idx, input logic [31:0] data);
      @(negedge clk);
      reg_wr_en = 1'b1;
      reg_wr_idx = idx;
      reg_wr_data = data;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic program_regs(input logic [31:0] s, input logic [31:0] d,
                               input logic [31:0] c, input logic [31:0] cc);
      reg_write(3'd1, s);
      reg_write(3'd2, d);
      reg_write(3'd3, c);
      reg_write(3'd4, cc);
   endtask

   task automatic clear_logs();
      n_rd = 0; n_wr = 0; done_cnt = 0; req_cycles = 0;
   endtask

   task automatic wait_done(input string req);
      int cyc = 0;
      do begin
         @(negedge clk); #1;
         cyc++;
      end while (!done && cyc < 4000);
      chk(req, "done seen before timeout", 32'(done), 32'd1);
      chk(req, "busy low with done", 32'(busy), 32'd0);
   endtask

   task automatic test_reset();
      @(negedge clk); #1;
      chk("R1", "busy in reset", 32'(busy), 0);
      chk("R1", "mem_req in reset", 32'(mem_req), 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk("R1", "done after reset", 32'(done), 0);
      chk("R1", "chained after reset", 32'(chained), 0);
      chk("R1", "stat_src after reset", stat_src, 0);
      chk("R1", "stat_cnt after reset", 32'(stat_cnt), 0);
   endtask

   task automatic test_regs();
      program_regs(32'h1111_2222, 32'h3333_4444, 32'h55, 32'h7);
      #1;
      chk("R2", "src register", stat_src, 32'h1111_2222);
      chk("R2", "dst register", stat_dst, 32'h3333_4444);
      chk("R2", "count register", 32'(stat_cnt), 32'h55);
      chk("R2", "still idle", 32'(busy), 0);
   endtask

   task automatic test_wide_inc();
      clear_logs();
      lat = 0;
      program_regs(32'h1000, 32'h2000, 3, 0);
      reg_write(3'd0, 32'h09);
      #1;
      chk("R3", "busy after go", 32'(busy), 1);
      chk("R3", "first request", 32'(mem_req), 1);
      chk("R3", "first is read", 32'(mem_we), 0);
      chk("R3", "first address", mem_addr, 32'h1000);
      wait_done("R7");
      chk("R7", "element count", 32'(n_wr), 3);
      for (int i = 0; i < 3; i++) begin
         chk("R4", "read address", rd_log[i], 32'h1000 + 32'(4*i));
         chk("R5", "write address", wa_log[i], 32'h2000 + 32'(4*i));
         chk("R4", "write data", wd_log[i], pat(32'h1000 + 32'(4*i)));
         chk("R11", "wide size", 32'(ws_log[i]), 1);
      end
      chk("R5", "final src", stat_src, 32'h100C);
      chk("R7", "final count", 32'(stat_cnt), 0);
      @(negedge clk); #1;
      chk("R7", "done one cycle", 32'(done), 0);
      chk("R7", "done pulse count", 32'(done_cnt), 1);
      chk("R7", "no request after done", 32'(mem_req), 0);
   endtask

   task automatic test_narrow_dec();
      clear_logs();
      lat = 2;
      program_regs(32'h3006, 32'h4106, 2, 0);
      reg_write(3'd0, 32'h07);
      #1;
      chk("R11", "narrow mem_size", 32'(mem_size), 0);
      wait_done("R7");
      chk("R4", "narrow element count", 32'(n_wr), 2);
      for (int i = 0; i < 2; i++) begin
         chk("R5", "dec read address", rd_log[i], 32'h3006 - 32'(2*i));
         chk("R5", "dec write address", wa_log[i], 32'h4106 - 32'(2*i));
         chk("R11", "narrow data upper zero", wd_log[i],
             {16'h0, pat(32'h3006 - 32'(2*i))[15:0]});
      end
      chk("R5", "final dec src", stat_src, 32'h3002);
      chk("R5", "final dec dst", stat_dst, 32'h4102);
   endtask

   task automatic test_chain(input int l);
      clear_logs();
      lat = l;
      program_regs(32'h5000, 32'h6000, 2, 3);
      reg_write(3'd0, 32'h19);
      wait_done("R8");
      chk("R8", "chained element count", 32'(n_wr), 5);
      for (int i = 0; i < 5; i++) begin
         chk("R8", "continued read address", rd_log[i], 32'h5000 + 32'(4*i));
         chk("R8", "continued write address", wa_log[i], 32'h6000 + 32'(4*i));
      end
      chk("R8", "chained flag", 32'(chained), 1);
      chk("R8", "single done pulse", 32'(done_cnt), 1);
      chk("R8", "final src", stat_src, 32'h5014);
      chk("R8", "final count", 32'(stat_cnt), 0);
   endtask

   task automatic test_chain_zero();
      clear_logs();
      lat = 0;
      program_regs(32'h5800, 32'h6800, 2, 0);
      reg_write(3'd0, 32'h19);
      wait_done("R8");
      chk("R8", "zero chain elements", 32'(n_wr), 2);
      chk("R8", "zero chain flag", 32'(chained), 0);
   endtask

   task automatic test_zero_count(input logic [31:0] ctl);
      clear_logs();
      program_regs(32'h9000, 32'hA000, 0, 4);
      reg_write(3'd0, ctl);
      #1;
      chk("R9", "done next cycle", 32'(done), 1);
      chk("R9", "not busy", 32'(busy), 0);
      repeat (4) @(negedge clk);
      #1;
      chk("R9", "no memory cycles", 32'(req_cycles), 0);
      chk("R9", "one done pulse", 32'(done_cnt), 1);
   endtask

   task automatic test_busy_writes();
      clear_logs();
      lat = 3;
      program_regs(32'h7000, 32'h8000, 3, 0);
      reg_write(3'd0, 32'h09);
      reg_write(3'd2, 32'hDEAD_0000);
      reg_write(3'd3, 32'd100);
      reg_write(3'd1, 32'h0);
      reg_write(3'd0, 32'h0F);
      wait_done("R10");
      chk("R10", "element count unchanged", 32'(n_wr), 3);
      for (int i = 0; i < 3; i++) begin
         chk("R10", "write address kept", wa_log[i], 32'h8000 + 32'(4*i));
         chk("R10", "read address kept", rd_log[i], 32'h7000 + 32'(4*i));
      end
      chk("R10", "final dst", stat_dst, 32'h800C);
      chk("R10", "final count", 32'(stat_cnt), 0);
   endtask

   initial begin
      test_reset();
      test_regs();
      test_wide_inc();
      test_narrow_dec();
      test_chain(0);
      test_chain(1);
      test_chain_zero();
      test_zero_count(32'h09);
      test_zero_count(32'h19);
      test_busy_writes();
      $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
   end

   initial begin
      #750000;
      n_checks++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
   end

endmodule